// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented logical address into a physical address. A request carries a segment number, an offset within that segment and an access kind: read, write or execute. The block first compares the segment number with the table length register. A number that is too large is rejected at once, and no memory access is made. For a legal number, the block reads the segment's two-word descriptor from a table in memory. The table's location comes from a table base register, and the reads use a request/acknowledge handshake. The block then applies its checks in a fixed order. It returns either the segment base plus the offset or a single trap code that names the first check that failed.

Requests are taken one at a time. The block shows that it is free by holding its ready output high. Each accepted request produces exactly one response, which lasts for one cycle. Descriptor word 0 holds the segment base in its low bits. Descriptor word 1 holds the following fields:
- the segment length in its low OFF_W+1 bits;
- the valid flag in the top bit;
- read permission in the bit below the valid flag;
- write permission in the bit below that;
- execute permission in the bit below that.

Top module: `seg_xlate`

## Requirements
- R1: A request whose segment number is greater than or equal to the table length register traps with code 1. Its response appears in the cycle after acceptance, and no memory request is made for it.
- R2: For a legal segment number s, the block reads two memory words. The first is at table base + 2*s and the second at table base + 2*s + 1. Each read holds mem_req high and mem_addr stable until mem_ack, and mem_rdata is taken in the acknowledge cycle.
- R3: A descriptor whose valid bit (top bit of word 1) is 0 traps with code 2, whatever its permissions and limit are.
- R4: Access codes are 0 read, 1 write, 2 execute and 3 none. Read is permitted by bit DATA_W-2 of word 1, write by bit DATA_W-3 and execute by bit DATA_W-4. Code 3 is never permitted. On a valid segment, an access without permission traps with code 3, even when the offset is also out of range.
- R5: On a valid, permitted access, an offset that is not strictly below the limit (low OFF_W+1 bits of word 1) traps with code 4. A limit of 0 makes every offset trap.
- R6: A legal access responds with trap code 0 and a physical address equal to base + offset, truncated to PA_W bits. Every trapped response carries physical address 0.
- R7: rsp_valid is a one-cycle pulse. With zero memory wait states it rises 3 cycles after acceptance for a legal segment number. Each wait state on either read adds one cycle.
- R8: req_ready is high only while the block is idle. A request presented while req_ready is low is ignored: it produces no response and no memory access.
- R9: After reset, req_ready is 1, and rsp_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | PA_W | Memory address of descriptor 0 |
| tbl_len | input | SEG_W+1 | Number of segments in the table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset inside the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_trap | output | 3 | 0 ok, 1 bad number, 2 invalid, 3 protection, 4 range |
| rsp_pa | output | PA_W | Physical address, 0 on a trap |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | PA_W | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DATA_W | Descriptor word |

## Verification
A segment number that is out of range gives its response one cycle after acceptance. A legal number gives its response 3 + 2w cycles after acceptance, where w is the number of wait states the bench memory inserts on each read. The bench varies w between vectors and counts sampling points from the acceptance edge. It requires the strobe to appear at exactly that count and to be gone one sample later. The descriptor read addresses and the number of reads are captured at the acknowledge edges and compared once the response has arrived.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    TRAP_NONE    = 3'd0,
    TRAP_SEG_NUM = 3'd1,
    TRAP_INVALID = 3'd2,
    TRAP_PROT    = 3'd3,
    TRAP_RANGE   = 3'd4
  } trap_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  // rwx = {read, write, execute} permission bits of a descriptor
  function automatic logic acc_permitted(logic [2:0] rwx, acc_e acc);
    case (acc)
      ACC_READ:  return rwx[2];
      ACC_WRITE: return rwx[1];
      ACC_EXEC:  return rwx[0];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seg_entry_fetch.sv
module seg_entry_fetch #(
  parameter int PA_W   = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PA_W-1:0]   entry_addr,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] base_word,
  output logic [DATA_W-1:0] attr_word
);

  typedef enum logic [1:0] {F_IDLE, F_BASE, F_ATTR} fstate_e;

  fstate_e           st;
  logic [PA_W-1:0]   addr_q;
  logic [DATA_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      addr_q <= '0;
      base_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          addr_q <= entry_addr;
          st     <= F_BASE;
        end
        F_BASE: if (mem_ack) begin
          base_q <= mem_rdata;
          st     <= F_ATTR;
        end
        F_ATTR: if (mem_ack) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign mem_req   = (st != F_IDLE);
  assign mem_addr  = addr_q + ((st == F_ATTR) ? PA_W'(1) : PA_W'(0));
  assign done      = (st == F_ATTR) && mem_ack;
  assign base_word = base_q;
  // second word is judged straight off the bus in its acknowledge cycle
  assign attr_word = mem_rdata;

endmodule

// File: rtl/seg_legality.sv
module seg_legality
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int PA_W   = 20,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_word,
  input  logic [DATA_W-1:0] attr_word,
  input  logic [OFF_W-1:0]  off,
  input  acc_e              acc,
  output trap_e             trap,
  output logic [PA_W-1:0]   pa
);

  localparam int LIM_W = OFF_W + 1;

  function automatic logic in_range(logic [OFF_W-1:0] o, logic [LIM_W-1:0] lim);
    return {1'b0, o} < lim;
  endfunction

  function automatic logic [PA_W-1:0] relocate(logic [PA_W-1:0] b, logic [OFF_W-1:0] o);
    return b + PA_W'(o);
  endfunction

  logic             seg_valid;
  logic [2:0]       rwx;
  logic [LIM_W-1:0] limit;

  assign seg_valid = attr_word[DATA_W-1];
  assign rwx       = attr_word[DATA_W-2:DATA_W-4];
  assign limit     = attr_word[LIM_W-1:0];

  always_comb begin
    if (!seg_valid)                   trap = TRAP_INVALID;
    else if (!acc_permitted(rwx, acc)) trap = TRAP_PROT;
    else if (!in_range(off, limit))   trap = TRAP_RANGE;
    else                              trap = TRAP_NONE;
  end

  assign pa = relocate(base_word[PA_W-1:0], off);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 6,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [SEG_W:0]    tbl_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [2:0]        rsp_trap,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RESP} state_e;

  function automatic logic seg_in_table(logic [SEG_W-1:0] s, logic [SEG_W:0] len);
    return {1'b0, s} < len;
  endfunction

  function automatic logic [PA_W-1:0] entry_of(logic [PA_W-1:0] b, logic [SEG_W-1:0] s);
    return b + PA_W'({s, 1'b0});
  endfunction

  state_e            st;
  logic [OFF_W-1:0]  off_q;
  acc_e              acc_q;
  trap_e             trap_q;
  logic [PA_W-1:0]   pa_q;

  // named internal events
  logic              accept;
  logic              seg_reject;
  logic              fetch_start;
  logic              fetch_done;
  logic [DATA_W-1:0] base_word;
  logic [DATA_W-1:0] attr_word;
  trap_e             chk_trap;
  logic [PA_W-1:0]   chk_pa;

  assign accept      = req_valid && (st == S_IDLE);
  assign seg_reject  = !seg_in_table(req_seg, tbl_len);
  assign fetch_start = accept && !seg_reject;

  seg_entry_fetch #(.PA_W(PA_W), .DATA_W(DATA_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_start),
    .entry_addr (entry_of(tbl_base, req_seg)),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .done       (fetch_done),
    .base_word  (base_word),
    .attr_word  (attr_word)
  );

  seg_legality #(.OFF_W(OFF_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_legal (
    .base_word (base_word),
    .attr_word (attr_word),
    .off       (off_q),
    .acc       (acc_q),
    .trap      (chk_trap),
    .pa        (chk_pa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      off_q  <= '0;
      acc_q  <= ACC_READ;
      trap_q <= TRAP_NONE;
      pa_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          off_q <= req_off;
          acc_q <= acc_e'(req_acc);
          if (seg_reject) begin
            trap_q <= TRAP_SEG_NUM;
            pa_q   <= '0;
            st     <= S_RESP;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (fetch_done) begin
          trap_q <= chk_trap;
          pa_q   <= (chk_trap == TRAP_NONE) ? chk_pa : '0;
          st     <= S_RESP;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_trap  = trap_q;
  assign rsp_pa    = pa_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 6,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic [SEG_W:0]   tbl_len,
  input logic             rsp_valid,
  input logic [2:0]       rsp_trap,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_ack,
  input logic             fetch_done
);

  // R1: out-of-table number answered next cycle with code 1
  a_r1_bad_seg_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=> (rsp_valid && rsp_trap == 3'd1));

  // R1: and without touching memory
  a_r1_no_mem_access: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=> !mem_req);

  // R2: read held steady until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R3/R4/R5: only defined codes leave the block
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_trap <= 3'd4));

  // R6: trapped responses carry no address
  a_r6_pa_zero_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap != 3'd0) |-> (rsp_pa == '0));

  // R7: single-cycle strobe, due right after the last descriptor word
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> rsp_valid);

  // R8: no memory traffic while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_seg    (req_seg),
  .tbl_len    (tbl_len),
  .rsp_valid  (rsp_valid),
  .rsp_trap   (rsp_trap),
  .rsp_pa     (rsp_pa),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .fetch_done (fetch_done)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

  localparam int SEG_W  = 4;
  localparam int OFF_W  = 8;
  localparam int PA_W   = 12;
  localparam int DATA_W = 16;
  localparam logic [PA_W-1:0] TBASE = 12'h010;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PA_W-1:0]   tbl_base = TBASE;
  logic [SEG_W:0]    tbl_len = 5'd5;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [SEG_W-1:0]  req_seg = '0;
  logic [OFF_W-1:0]  req_off = '0;
  logic [1:0]        req_acc = '0;
  logic              rsp_valid;
  logic [2:0]        rsp_trap;
  logic [PA_W-1:0]   rsp_pa;
  logic              mem_req;
  logic [PA_W-1:0]   mem_addr;
  logic              mem_ack;
  logic [DATA_W-1:0] mem_rdata;

  always #2 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_trap(rsp_trap), .rsp_pa(rsp_pa), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with programmable wait states
  logic [DATA_W-1:0] mem [64];
  int                wait_cfg = 0;
  int                wcnt = 0;
  int                n_acc = 0;
  logic [PA_W-1:0]   hist0 = '0, hist1 = '0;

  assign mem_ack   = mem_req && (wcnt == wait_cfg);
  assign mem_rdata = mem[mem_addr[5:0]];

  always @(posedge clk) begin
    if (mem_req && !mem_ack) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (mem_req && mem_ack) begin
      n_acc <= n_acc + 1;
      hist0 <= hist1;
      hist1 <= mem_addr;
    end
  end

  // descriptor: word0 base; word1 {V,R,W,X,...,limit[8:0]}
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[16] = 16'h0100; mem[17] = 16'hD040; // seg0 R-X limit 0x40
    mem[18] = 16'h0200; mem[19] = 16'hE100; // seg1 RW- limit 0x100
    mem[20] = 16'h0300; mem[21] = 16'h7010; // seg2 invalid, RWX
    mem[22] = 16'h0F80; mem[23] = 16'hA080; // seg3 -W- limit 0x80
    mem[24] = 16'h0050; mem[25] = 16'hF000; // seg4 RWX limit 0
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {seg, off, acc, trap, pa}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {4'd0,  8'h00, 2'd0, 3'd0, 12'h100},
    {4'd0,  8'h3F, 2'd2, 3'd0, 12'h13F},
    {4'd0,  8'h40, 2'd0, 3'd4, 12'h000},
    {4'd0,  8'h10, 2'd1, 3'd3, 12'h000},
    {4'd1,  8'hFF, 2'd1, 3'd0, 12'h2FF},
    {4'd1,  8'h00, 2'd2, 3'd3, 12'h000},
    {4'd2,  8'h00, 2'd0, 3'd2, 12'h000},
    {4'd2,  8'h20, 2'd2, 3'd2, 12'h000},
    {4'd3,  8'h7F, 2'd1, 3'd0, 12'hFFF},
    {4'd3,  8'h80, 2'd0, 3'd3, 12'h000},
    {4'd4,  8'h00, 2'd0, 3'd4, 12'h000},
    {4'd5,  8'h00, 2'd0, 3'd1, 12'h000},
    {4'd15, 8'h00, 2'd2, 3'd1, 12'h000},
    {4'd1,  8'h80, 2'd3, 3'd3, 12'h000}
  };

  task automatic run(input logic [3:0] s, input logic [7:0] o, input logic [1:0] a,
                     input int w, output int lat, output logic [2:0] tr,
                     output logic [PA_W-1:0] pa, output int nacc);
    int acc0;
    wait_cfg = w;
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    acc0 = n_acc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    tr = rsp_trap; pa = rsp_pa; nacc = n_acc - acc0;
    @(negedge clk);
    chk(!rsp_valid, "R7 pulse width", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, nacc, exp_lat;
    logic [2:0] tr;
    logic [PA_W-1:0] pa;
    logic [3:0] s;
    logic [2:0] etr;
    logic [11:0] epa;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready === 1'b1, "R9 ready", req_ready, 1);
    chk(rsp_valid === 1'b0, "R9 rsp_valid", rsp_valid, 0);
    chk(mem_req === 1'b0, "R9 mem_req", mem_req, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      s   = VEC[i][28:25];
      etr = VEC[i][14:12];
      epa = VEC[i][11:0];
      run(s, VEC[i][24:17], VEC[i][16:15], i % 3, lat, tr, pa, nacc);
      // R1 R3 R4 R5 trap code, R6 address
      chk(tr == etr, $sformatf("R3/R4/R5/R1 trap v%0d", i), tr, etr);
      chk(pa == epa, $sformatf("R6 pa v%0d", i), pa, epa);
      exp_lat = (etr == 3'd1) ? 1 : 3 + 2 * (i % 3);
      chk(lat == exp_lat, $sformatf("R7 latency v%0d", i), lat, exp_lat);
      if (etr == 3'd1) begin
        chk(nacc == 0, $sformatf("R1 no access v%0d", i), nacc, 0);
      end else begin
        chk(nacc == 2, $sformatf("R2 reads v%0d", i), nacc, 2);
        chk(hist0 == TBASE + 2 * s, $sformatf("R2 addr0 v%0d", i), hist0, TBASE + 2 * s);
        chk(hist1 == TBASE + 2 * s + 1, $sformatf("R2 addr1 v%0d", i), hist1, TBASE + 2 * s + 1);
      end
    end

    // R1 empty table rejects segment 0
    tbl_len = '0;
    run(4'd0, 8'h00, 2'd0, 0, lat, tr, pa, nacc);
    chk(tr == 3'd1, "R1 empty table", tr, 1);
    chk(nacc == 0, "R1 empty table access", nacc, 0);
    tbl_len = 5'd5;

    // R8 request while busy is ignored
    wait_cfg = 1;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'd0; req_off = 8'h05; req_acc = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
    req_seg = 4'd15; // stays asserted, would trap immediately if taken
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp_trap == 3'd0, "R8 trap of first request", rsp_trap, 0);
    chk(rsp_pa == 12'h105, "R8 pa of first request", rsp_pa, 12'h105);
    req_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!rsp_valid, "R8 no extra response", rsp_valid, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule